// File: doc/BRIEF.md
# Flash Status Poll Flag Generator

This block forms the status byte that a flash program/erase engine presents on its read path while an operation is running. Each cycle it takes the state of the engine (programming, erasing, block-selection window open, chip-wide erase, suspended), an error event and its clear, the bit 7 of the word being written, the read address and a read strobe. It also takes one mask of the blocks chosen for erase and one mask of the blocks whose erase failed. From these it drives a registered 8-bit read value and a registered ready flag.

Two toggle flip-flops give the polling behaviour. The first flips on every completed read while the engine is working. The second flips only for reads whose address falls in a block that matters: a block being erased, or, once an error is latched, a block that failed. The block index is the read address shifted right by `BLK_SHIFT`, so all blocks are the same size. While the engine is suspended, reads outside the erased blocks return the array word unchanged. When no operation is active, the array word is also passed through.

Top module: `flash_status_flags`

## Requirements
- R1: After reset `rd_data` is 0x00, `ready` is 1 and both toggle bits start at 0.
- R2: While `op_prog` is 1, `rd_data` is {~`prog_bit7`, T6, ERR, 0, 0, 0, 0, 0} (bit 7 down to bit 0). Bits 4, 3, 2, 1 and 0 are 0.
- R3: While `op_erase` is 1, `op_prog` is 0 and `suspended` is 0, `rd_data` bit 7 is 0 and bits 4, 1 and 0 are 0.
- R4: T6 (`rd_data` bit 6) inverts once for each completed read strobe (a 1 then 0 on `rd_strobe`), at any address, while `op_prog` is 1 or while `op_erase` is 1 with `suspended` at 0.
- R5: While `op_erase` and `suspended` are 1 and `op_prog` is 0, T6 does not change on reads.
- R6: A one-cycle `op_fail` sets ERR (`rd_data` bit 5). ERR stays 1 until a `clr_err` cycle, which has priority.
- R7: During an unsuspended erase, bit 3 is 0 while `erase_window` is 1 and 1 when it is 0. Bit 3 is always 1 when `erase_chip` is 1.
- R8: With no error latched, T2 (`rd_data` bit 2) inverts on a completed read during an erase only if the addressed block is selected (its `erase_mask` bit is set, or `erase_chip` is 1). Reads from other blocks leave it unchanged.
- R9: With ERR set during an erase, T2 inverts only for reads in blocks whose `fail_mask` bit is 1.
- R10: While suspended (`op_erase`=1, `suspended`=1, `op_prog`=0), a read from a selected block gives {1, T6, ERR, 0, 0, T2, 0, 0}. A read from any other block gives `array_data`.
- R11: `ready` is 0 while `op_prog` is 1, or while `op_erase` is 1 and `suspended` is 0. Otherwise it is 1.
- R12: A one-cycle `op_start` sets T6 and T2 to 0.
- R13: With neither `op_prog` nor `op_erase` set, `rd_data` equals `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Pulse when a new operation begins; clears the toggles |
| op_prog | input | 1 | A program operation is active |
| op_erase | input | 1 | An erase operation is active, including while suspended |
| erase_window | input | 1 | Block-selection window still open |
| erase_chip | input | 1 | The erase covers every block |
| suspended | input | 1 | The erase is suspended |
| op_fail | input | 1 | Pulse when the operation fails |
| clr_err | input | 1 | Pulse when a reset command is accepted |
| prog_bit7 | input | 1 | Bit 7 of the word being programmed |
| rd_addr | input | ADDR_W | Read address |
| rd_strobe | input | 1 | Read strobe; the read completes on its falling edge |
| erase_mask | input | NUM_BLOCKS | Blocks selected for erase |
| fail_mask | input | NUM_BLOCKS | Blocks that failed to erase |
| array_data | input | 8 | Normal array word for the read address |
| rd_data | output | 8 | Registered read value |
| ready | output | 1 | Registered ready flag, 1 = released |

## Verification
The bench runs the block with four blocks and sweeps every erase mask against a read in every block. A read in a selected block must flip bit 2 and a read in an unselected block must not, so this sweep separates wrong block decoding from a wrong toggle rule. The same sweep is repeated with the failure mask after an error, which shows whether bit 2 follows the failure mask instead of the erase mask. The program path is tried with both values of the written bit 7 over repeated reads, which shows both the polarity of bit 7 and that bit 6 steps once per read. Suspended reads are compared against the array word for unselected blocks, and against a bit 6 that stays fixed for selected blocks.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  typedef struct packed {
    logic poll;      // bit 7
    logic tog_any;   // bit 6
    logic err;       // bit 5
    logic rsv4;      // bit 4
    logic started;   // bit 3
    logic tog_blk;   // bit 2
    logic [1:0] rsv; // bits 1:0
  } status_t;

  function automatic logic [7:0] pack_status(input logic poll, input logic t6,
                                             input logic err, input logic started,
                                             input logic t2);
    status_t s;
    s.poll    = poll;
    s.tog_any = t6;
    s.err     = err;
    s.rsv4    = 1'b0;
    s.started = started;
    s.tog_blk = t2;
    s.rsv     = 2'b00;
    return s;
  endfunction
endpackage

// File: rtl/fsf_read_done.sv
module fsf_read_done (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic done
);
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  assign done = strobe_q & ~strobe;
endmodule

// File: rtl/fsf_toggle.sv
module fsf_toggle (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= 1'b0;
    else if (en)    q <= ~q;
  end

  AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(q)); // R4
  AST_TOGGLE_CLR: assert property (@(posedge clk) disable iff (rst)
    clr |=> !q); // R12
endmodule

// File: rtl/fsf_block_lookup.sv
module fsf_block_lookup #(
  parameter int NUM_BLOCKS = 8,
  parameter int ADDR_W     = 12,
  parameter int BLK_SHIFT  = 9
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_BLOCKS-1:0] sel_mask,
  input  logic [NUM_BLOCKS-1:0] bad_mask,
  output logic                  sel_hit,
  output logic                  bad_hit
);
  logic [ADDR_W-1:0] blk;
  assign blk = addr >> BLK_SHIFT;

  logic [NUM_BLOCKS-1:0] onehot;
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_dec
    assign onehot[i] = (blk == ADDR_W'(i));
  end

  assign sel_hit = |(onehot & sel_mask);
  assign bad_hit = |(onehot & bad_mask);
endmodule

// File: rtl/flash_status_flags.sv
module flash_status_flags
  import fsf_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int ADDR_W     = 12,
  parameter int BLK_SHIFT  = ADDR_W - $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_start,
  input  logic                  op_prog,
  input  logic                  op_erase,
  input  logic                  erase_window,
  input  logic                  erase_chip,
  input  logic                  suspended,
  input  logic                  op_fail,
  input  logic                  clr_err,
  input  logic                  prog_bit7,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic                  rd_strobe,
  input  logic [NUM_BLOCKS-1:0] erase_mask,
  input  logic [NUM_BLOCKS-1:0] fail_mask,
  input  logic [7:0]            array_data,
  output logic [7:0]            rd_data,
  output logic                  ready
);
  localparam logic [NUM_BLOCKS-1:0] ALL_BLOCKS = '1;

  logic done, t6, t2, err_q;
  logic sel_hit, bad_hit;
  logic erase_run, erase_susp, busy;
  logic [NUM_BLOCKS-1:0] sel_mask;

  assign sel_mask   = erase_chip ? ALL_BLOCKS : erase_mask;
  assign erase_run  = op_erase & ~op_prog & ~suspended;
  assign erase_susp = op_erase & ~op_prog & suspended;
  assign busy       = op_prog | erase_run;

  fsf_read_done u_done (.clk(clk), .rst(rst), .strobe(rd_strobe), .done(done));

  fsf_block_lookup #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_lookup (
    .addr(rd_addr), .sel_mask(sel_mask), .bad_mask(fail_mask),
    .sel_hit(sel_hit), .bad_hit(bad_hit)
  );

  logic t6_en, t2_en;
  assign t6_en = done & busy;
  assign t2_en = done & op_erase & ~op_prog & (err_q ? bad_hit : sel_hit);

  fsf_toggle u_t6 (.clk(clk), .rst(rst), .clr(op_start), .en(t6_en), .q(t6));
  fsf_toggle u_t2 (.clk(clk), .rst(rst), .clr(op_start), .en(t2_en), .q(t2));

  always_ff @(posedge clk) begin
    if (rst || clr_err) err_q <= 1'b0;
    else if (op_fail)   err_q <= 1'b1;
  end

  logic [7:0] nxt;
  always_comb begin
    if (op_prog)
      nxt = pack_status(~prog_bit7, t6, err_q, 1'b0, 1'b0);
    else if (erase_susp)
      nxt = sel_hit ? pack_status(1'b1, t6, err_q, 1'b0, t2) : array_data;
    else if (op_erase)
      nxt = pack_status(1'b0, t6, err_q, erase_chip | ~erase_window, t2);
    else
      nxt = array_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= 8'h00;
      ready   <= 1'b1;
    end else begin
      rd_data <= nxt;
      ready   <= ~busy;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !clr_err) |=> err_q); // R6
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (rst)
    op_prog |=> (rd_data[7] == !$past(prog_bit7))); // R2
  AST_PROG_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    op_prog |=> (rd_data[4:0] == 5'b0)); // R2
  AST_T6_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (erase_susp && !op_start) |=> $stable(t6)); // R5
  AST_T2_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!op_erase && !op_start) |=> $stable(t2)); // R8
  AST_BUSY_LOW: assert property (@(posedge clk) disable iff (rst)
    erase_run |=> !ready); // R11
endmodule

// File: tb/flash_status_flags_tb.sv
module flash_status_flags_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = 8;

  logic clk = 0, rst = 1;
  logic op_start = 0, op_prog = 0, op_erase = 0, erase_window = 0, erase_chip = 0;
  logic suspended = 0, op_fail = 0, clr_err = 0, prog_bit7 = 0, rd_strobe = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [NB-1:0] erase_mask = '0, fail_mask = '0;
  logic [7:0] array_data = 8'h00;
  logic [7:0] rd_data;
  logic ready;

  int checks = 0, failures = 0;
  logic m_t6 = 0, m_t2 = 0, m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_flags #(.NUM_BLOCKS(NB), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .op_start(op_start), .op_prog(op_prog), .op_erase(op_erase),
    .erase_window(erase_window), .erase_chip(erase_chip), .suspended(suspended),
    .op_fail(op_fail), .clr_err(clr_err), .prog_bit7(prog_bit7), .rd_addr(rd_addr),
    .rd_strobe(rd_strobe), .erase_mask(erase_mask), .fail_mask(fail_mask),
    .array_data(array_data), .rd_data(rd_data), .ready(ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic sel_blk(input int b);
    return erase_chip ? 1'b1 : erase_mask[b];
  endfunction

  function automatic logic [7:0] model();
    int b = int'(rd_addr >> 6);
    if (op_prog) return {~prog_bit7, m_t6, m_err, 5'b0};
    if (op_erase && suspended)
      return sel_blk(b) ? {1'b1, m_t6, m_err, 2'b00, m_t2, 2'b00} : array_data;
    if (op_erase) return {1'b0, m_t6, m_err, 1'b0, erase_chip | ~erase_window, m_t2, 2'b00};
    return array_data;
  endfunction

  function automatic logic model_ready();
    return !(op_prog || (op_erase && !suspended));
  endfunction

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input int b, input logic [5:0] off);
    @(negedge clk);
    rd_addr = {b[1:0], off};
    rd_strobe = 1;
    @(negedge clk);
    rd_strobe = 0;
    if (op_prog || (op_erase && !suspended)) m_t6 = ~m_t6;
    if (op_erase && !op_prog && (m_err ? fail_mask[b] : sel_blk(b))) m_t2 = ~m_t2;
    settle();
  endtask

  task automatic pulse_start();
    @(negedge clk); op_start = 1;
    @(negedge clk); op_start = 0;
    m_t6 = 0; m_t2 = 0;
    settle();
  endtask

  task automatic pulse_fail();
    @(negedge clk); op_fail = 1;
    @(negedge clk); op_fail = 0;
    m_err = 1;
    settle();
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_err = 1;
    @(negedge clk); clr_err = 0;
    m_err = 0;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset data", rd_data, 8'h00);
    chk("R1 reset ready", {7'b0, ready}, 8'h01);
    rst = 0;

    // R13 idle pass-through
    for (int v = 0; v < 8; v++) begin
      array_data = 8'(v * 37 + 5);
      settle();
      chk("R13 idle array", rd_data, model());
    end

    // R2 R4 program polling
    for (int p = 0; p < 2; p++) begin
      op_prog = 1; prog_bit7 = p[0];
      pulse_start();
      chk("R11 ready during program", {7'b0, ready}, 8'h00);
      for (int r = 0; r < 3; r++) begin
        do_read(r, 6'(r * 7));
        chk("R2 R4 program status", rd_data, model());
      end
    end
    op_prog = 0;
    settle();
    chk("R11 ready idle", {7'b0, ready}, 8'h01);

    // R3 R7 R8 erase sweep: window open then closed
    op_erase = 1;
    pulse_start();
    for (int w = 0; w < 2; w++) begin
      erase_window = w[0] ? 1'b0 : 1'b1;
      for (int m = 0; m < 16; m++) begin
        erase_mask = 4'(m);
        for (int b = 0; b < NB; b++) begin
          do_read(b, 6'h15);
          chk("R3 R7 R8 erase status", rd_data, model());
        end
      end
    end
    chk("R11 ready during erase", {7'b0, ready}, 8'h00);

    // R7 chip erase
    erase_chip = 1; erase_window = 1; erase_mask = '0;
    for (int b = 0; b < NB; b++) begin
      do_read(b, 6'h02);
      chk("R7 R8 chip erase status", rd_data, model());
    end
    erase_chip = 0; erase_window = 0;

    // R6 R9 error, failure mask sweep
    erase_mask = 4'hF;
    pulse_fail();
    for (int m = 0; m < 16; m++) begin
      fail_mask = 4'(m);
      for (int b = 0; b < NB; b++) begin
        do_read(b, 6'h3A);
        chk("R6 R9 error status", rd_data, model());
      end
    end
    pulse_clr();
    chk("R6 error cleared", rd_data, model());

    // R5 R10 suspend
    pulse_start();
    do_read(0, 6'h01);
    erase_mask = 4'b0101; suspended = 1; array_data = 8'h5C;
    settle();
    chk("R11 ready suspended", {7'b0, ready}, 8'h01);
    for (int b = 0; b < NB; b++) begin
      do_read(b, 6'h10);
      chk("R5 R10 suspended read", rd_data, model());
    end
    do_read(2, 6'h11);
    chk("R5 R10 suspended repeat", rd_data, model());

    // R12 op_start clears toggles
    suspended = 0;
    do_read(0, 6'h00);
    pulse_start();
    chk("R12 toggles cleared", rd_data, {1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00});
    op_erase = 0;
    settle();
    chk("R13 idle after erase", rd_data, 8'h5C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule